// File: doc/BRIEF.md
# RC5-32/12 Pipelined Block Encryptor

This block encrypts 64-bit plaintext blocks with the RC5 cipher using 32-bit words and twelve rounds. Each block arrives as an upper and a lower 32-bit word together with its own expanded round-key table of 26 words, qualified by a single valid bit. The block returns the matching ciphertext words with a valid bit after a fixed number of clocks. It does not expand user keys and it does not decrypt. A key-search engine is one intended user: it feeds one candidate key table per clock and compares each ciphertext against a known target.

The datapath is a straight pipeline. A whitening stage adds the first two table words to the plaintext. Twelve round stages follow, and each has a fixed depth of six registers. The first register of a round computes the new upper word, the second computes the new lower word, and the remaining four only balance the timing. The table words that a round needs travel beside the data in per-round delay lines, so every block meets its own keys even when the table changes on every clock. No state machine is involved: every register stage advances unconditionally on each clock, and the valid bit moves with its block.

Top module: `rc5_enc_pipe`

## Requirements
- R1: `out_valid` follows `in_valid` by exactly 73 clocks (1 whitening register plus 12 rounds of 6 registers). An input sampled at a rising edge appears on the outputs after the 73rd rising edge that counts that edge as the first.
- R2: Whitening adds table word S[0] to `pt_hi` and S[1] to `pt_lo` before the first round.
- R3: In round i (i = 1..12) the upper word becomes ((upper XOR lower) rotated left by lower) + S[2i], and the lower word then becomes ((lower XOR new upper) rotated left by new upper) + S[2i+1]. After round 12, `ct_hi` holds the upper word and `ct_lo` the lower word.
- R4: A rotation amount uses only bits [4:0] of its controlling word. Higher bits have no effect.
- R5: A new block may enter on every clock. Each block is encrypted under the table that was presented with it, even when adjacent blocks carry different tables.
- R6: `rst_n` is an active-low asynchronous reset. While it is low, `out_valid` is 0. Blocks in flight when reset is asserted never emerge, and no `out_valid` appears within 73 clocks after release unless a new block was presented.
- R7: Table word S[k] (k = 0..25) is read from `key_tab[32k+31:32k]`.
- R8: A clock with `in_valid` low is ignored whatever the data and table inputs hold: its output slot 73 clocks later has `out_valid` low.
- R9: Every addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies plaintext and key table this clock |
| pt_hi | input | 32 | Upper plaintext word |
| pt_lo | input | 32 | Lower plaintext word |
| key_tab | input | 832 | Round-key table, word k at bits [32k+31:32k] |
| out_valid | output | 1 | Qualifies the ciphertext this clock |
| ct_hi | output | 32 | Upper ciphertext word |
| ct_lo | output | 32 | Lower ciphertext word |

## Verification
Two events can fall on the same clock: a new block with a fresh key table entering, and an older block leaving with the ciphertext derived from a table that is long gone from the inputs. Long runs of back-to-back blocks, each with its own random table, keep both events active on every clock once the pipeline is full. A behavioural reference computes the expected ciphertext when each block is accepted and queues it for exactly 73 clocks. The output is compared on every clock, so a key word delayed by the wrong amount or a block slot shifted by one cycle shows up as a mismatch. A reset asserted while the pipeline is full checks the other overlap: discarding blocks in flight against the first new outputs after release.

// File: rtl/rc5_pkg.sv
package rc5_pkg;

    localparam int WORD_W = 32;
    localparam int ROT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } rc5_blk_t;

    // Left rotation; only ROT_W bits of the amount are meaningful.
    function automatic logic [WORD_W-1:0] rotl(
        input logic [WORD_W-1:0] x,
        input logic [ROT_W-1:0]  s
    );
        logic [2*WORD_W-1:0] t;
        t = {x, x} << s;
        return t[2*WORD_W-1:WORD_W];
    endfunction

endpackage

// File: rtl/rc5_delay.sv
module rc5_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_sr
            logic [WIDTH-1:0] sr [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
                end
            end

            assign q = sr[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/rc5_whiten.sv
module rc5_whiten
    import rc5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  rc5_blk_t          blk_i,
    input  logic [WORD_W-1:0] ka_i,
    input  logic [WORD_W-1:0] kb_i,
    output logic              v_o,
    output rc5_blk_t          blk_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            blk_o <= '0;
        end else begin
            v_o      <= v_i;
            blk_o.hi <= blk_i.hi + ka_i;
            blk_o.lo <= blk_i.lo + kb_i;
        end
    end

endmodule

// File: rtl/rc5_round.sv
module rc5_round
    import rc5_pkg::*;
#(
    parameter int LAT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  rc5_blk_t          blk_i,
    input  logic [WORD_W-1:0] ka_i,
    input  logic [WORD_W-1:0] kb_i,
    output logic              v_o,
    output rc5_blk_t          blk_o
);

    localparam int PAD   = LAT - 2;
    localparam int BAL_W = 1 + 2*WORD_W;

    // first half-round register
    logic              s1_v;
    logic [WORD_W-1:0] s1_le;
    logic [WORD_W-1:0] s1_re;
    logic [WORD_W-1:0] s1_kb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v  <= 1'b0;
            s1_le <= '0;
            s1_re <= '0;
            s1_kb <= '0;
        end else begin
            s1_v  <= v_i;
            s1_le <= rotl(blk_i.hi ^ blk_i.lo, blk_i.lo[ROT_W-1:0]) + ka_i;
            s1_re <= blk_i.lo;
            s1_kb <= kb_i;
        end
    end

    // second half-round register
    logic     s2_v;
    rc5_blk_t s2_blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v   <= 1'b0;
            s2_blk <= '0;
        end else begin
            s2_v      <= s1_v;
            s2_blk.hi <= s1_le;
            s2_blk.lo <= rotl(s1_re ^ s1_le, s1_le[ROT_W-1:0]) + s1_kb;
        end
    end

    // balancing registers up to the fixed round depth
    logic [BAL_W-1:0] bal_q;

    rc5_delay #(
        .WIDTH (BAL_W),
        .DEPTH (PAD)
    ) u_bal (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({s2_v, s2_blk}),
        .q     (bal_q)
    );

    assign v_o   = bal_q[BAL_W-1];
    assign blk_o = bal_q[BAL_W-2:0];

endmodule

// File: rtl/rc5_enc_pipe.sv
module rc5_enc_pipe
    import rc5_pkg::*;
#(
    parameter int ROUNDS    = 12,
    parameter int ROUND_LAT = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [WORD_W-1:0]                   pt_hi,
    input  logic [WORD_W-1:0]                   pt_lo,
    input  logic [(2*ROUNDS+2)*WORD_W-1:0]      key_tab,
    output logic                                out_valid,
    output logic [WORD_W-1:0]                   ct_hi,
    output logic [WORD_W-1:0]                   ct_lo
);

    localparam int NKEYS     = 2*ROUNDS + 2;
    localparam int WHITE_LAT = 1;
    localparam int LAT_TOTAL = WHITE_LAT + ROUNDS*ROUND_LAT;

    rc5_blk_t pt_blk;
    logic     w_valid;
    rc5_blk_t w_blk;

    assign pt_blk.hi = pt_hi;
    assign pt_blk.lo = pt_lo;

    rc5_whiten u_white (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (in_valid),
        .blk_i (pt_blk),
        .ka_i  (key_tab[0 +: WORD_W]),
        .kb_i  (key_tab[WORD_W +: WORD_W]),
        .v_o   (w_valid),
        .blk_o (w_blk)
    );

    logic [ROUNDS:0] rv;
    rc5_blk_t        rb [ROUNDS+1];

    assign rv[0] = w_valid;
    assign rb[0] = w_blk;

    generate
        for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
            localparam int KDLY = WHITE_LAT + r*ROUND_LAT;
            localparam int KOFS = (2*r + 2) * WORD_W;

            logic [2*WORD_W-1:0] kd;

            rc5_delay #(
                .WIDTH (2*WORD_W),
                .DEPTH (KDLY)
            ) u_kdly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (key_tab[KOFS +: 2*WORD_W]),
                .q     (kd)
            );

            rc5_round #(
                .LAT   (ROUND_LAT)
            ) u_rnd (
                .clk   (clk),
                .rst_n (rst_n),
                .v_i   (rv[r]),
                .blk_i (rb[r]),
                .ka_i  (kd[WORD_W-1:0]),
                .kb_i  (kd[2*WORD_W-1:WORD_W]),
                .v_o   (rv[r+1]),
                .blk_o (rb[r+1])
            );
        end
    endgenerate

    assign out_valid = rv[ROUNDS];
    assign ct_hi     = rb[ROUNDS].hi;
    assign ct_lo     = rb[ROUNDS].lo;

endmodule

// File: rtl/rc5_enc_chk.sv
module rc5_enc_chk #(
    parameter int LAT = 73,
    parameter int W   = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] pt_hi,
    input logic [W-1:0] key_s0,
    input logic         w_valid,
    input logic [W-1:0] w_hi,
    input logic [W-1:0] ct_hi,
    input logic [W-1:0] ct_lo
);

    localparam int CW = $clog2(LAT + 2);

    logic          warm;
    logic [CW-1:0] since_rst;
    logic [CW-1:0] idle;
    logic [CW-1:0] inflight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm      <= 1'b0;
            since_rst <= '0;
            idle      <= CW'(LAT);
            inflight  <= '0;
        end else begin
            warm <= 1'b1;
            if (since_rst < CW'(LAT)) since_rst <= since_rst + 1'b1;
            if (in_valid)                idle <= '0;
            else if (idle < CW'(LAT))    idle <= idle + 1'b1;
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
        end
    end

    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_rst >= CW'(LAT)));                          // R6

    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));                                 // R1

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(LAT));                                           // R5

    AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idle < CW'(LAT)));                                // R8

    AST_WHITEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid)) |-> (w_valid && (w_hi == W'($past(pt_hi) + $past(key_s0))))); // R2

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown({ct_hi, ct_lo}));                      // R3

endmodule

bind rc5_enc_pipe rc5_enc_chk #(
    .LAT (LAT_TOTAL),
    .W   (rc5_pkg::WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .pt_hi     (pt_hi),
    .key_s0    (key_tab[rc5_pkg::WORD_W-1:0]),
    .w_valid   (w_valid),
    .w_hi      (w_blk.hi),
    .ct_hi     (ct_hi),
    .ct_lo     (ct_lo)
);

// File: tb/test_rc5_enc_pipe.sv
module test_rc5_enc_pipe;

    localparam int W    = 32;
    localparam int NK   = 26;
    localparam int LAT  = 73;
    localparam int KT_W = NK*W;

    typedef struct packed {
        logic         v;
        logic [W-1:0] h;
        logic [W-1:0] l;
        logic [7:0]   tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [W-1:0]    pt_hi = '0;
    logic [W-1:0]    pt_lo = '0;
    logic [KT_W-1:0] key_tab = '0;
    logic            out_valid;
    logic [W-1:0]    ct_hi;
    logic [W-1:0]    ct_lo;

    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    int   cur_tag = 6;
    bit   done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    rc5_enc_pipe i_rc5_enc_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .pt_hi     (pt_hi),
        .pt_lo     (pt_lo),
        .key_tab   (key_tab),
        .out_valid (out_valid),
        .ct_hi     (ct_hi),
        .ct_lo     (ct_lo)
    );

    function automatic string tname(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [W-1:0] rot(logic [W-1:0] x, logic [W-1:0] amt);
        int s;
        s = int'(amt % 32);
        if (s == 0) return x;
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic logic [2*W-1:0] ref_enc(logic [W-1:0] a, logic [W-1:0] b,
                                               logic [KT_W-1:0] kt);
        logic [W-1:0] le, re;
        le = a + kt[0 +: W];
        re = b + kt[W +: W];
        for (int i = 1; i <= 12; i++) begin
            le = rot(le ^ re, re) + kt[(2*i)*W +: W];
            re = rot(re ^ le, le) + kt[(2*i+1)*W +: W];
        end
        return {le, re};
    endfunction

    task automatic check(bit ok, int tag, string what, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tname(tag), what, act, exp);
        end
    endtask

    // reference model: capture at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
        end else begin
            exp_t e;
            logic [2*W-1:0] c;
            c     = ref_enc(pt_hi, pt_lo, key_tab);
            e.v   = in_valid;
            e.h   = c[2*W-1:W];
            e.l   = c[W-1:0];
            e.tag = 8'(cur_tag);
            q.push_back(e);
        end
    end

    // comparison, every cycle, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (!done) begin
            if (!rst_n) begin
                check(out_valid == 1'b0, 6, "out_valid during reset", 64'(out_valid), 64'd0);
            end else if (q.size() >= LAT) begin
                exp_t e;
                e = q.pop_front();
                check(out_valid == e.v, int'(e.tag), "out_valid slot", 64'(out_valid), 64'(e.v));
                if (e.v)
                    check({ct_hi, ct_lo} == {e.h, e.l}, int'(e.tag), "ciphertext",
                          {ct_hi, ct_lo}, {e.h, e.l});
            end else begin
                check(out_valid == 1'b0, 6, "out_valid before pipeline fill", 64'(out_valid), 64'd0);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic rand_keys(output logic [KT_W-1:0] kt);
        for (int k = 0; k < NK; k++) kt[k*W +: W] = $urandom;
    endtask

    task automatic put(logic v, logic [W-1:0] a, logic [W-1:0] b, logic [KT_W-1:0] kt);
        in_valid = v;
        pt_hi    = a;
        pt_lo    = b;
        key_tab  = kt;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        logic [KT_W-1:0] kt;
        for (int i = 0; i < n; i++) begin
            rand_keys(kt);
            put(1'b0, $urandom, $urandom, kt);
        end
    endtask

    initial begin
        logic [KT_W-1:0] kt;
        int lat;

        // R6: reset state
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = 6;
        idle(3);

        // R1: measured latency of a lone block
        cur_tag = 1;
        rand_keys(kt);
        in_valid = 1'b1; pt_hi = $urandom; pt_lo = $urandom; key_tab = kt;
        lat = 0;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(lat == LAT, 1, "latency in clocks", 64'(lat), 64'(LAT));
        idle(5);

        // R2: whitening words only, then all zero
        cur_tag = 2;
        kt = '0;
        kt[0 +: W] = 32'h1234_5678;
        kt[W +: W] = 32'h9abc_def0;
        put(1'b1, 32'h0, 32'h0, kt);
        put(1'b1, 32'h0, 32'h0, '0);
        put(1'b1, 32'hdead_beef, 32'h0bad_f00d, kt);
        idle(4);

        // R3: random blocks with gaps
        cur_tag = 3;
        for (int i = 0; i < 12; i++) begin
            rand_keys(kt);
            put(1'b1, $urandom, $urandom, kt);
            if (i % 3 == 0) idle(1);
        end

        // R4: control words with high bits set
        cur_tag = 4;
        for (int i = 0; i < 8; i++) begin
            rand_keys(kt);
            for (int k = 0; k < NK; k++) kt[k*W +: W] = kt[k*W +: W] | 32'hffff_ffe0;
            put(1'b1, 32'hffff_ffe0 | i, 32'h8000_0020 | (i * 7), kt);
        end

        // R9: wrap-around sums
        cur_tag = 9;
        put(1'b1, 32'hffff_ffff, 32'hffff_ffff, '1);
        put(1'b1, 32'h8000_0000, 32'h7fff_ffff, '1);
        idle(2);

        // R7: one nonzero table word at a time
        cur_tag = 7;
        for (int k = 0; k < NK; k++) begin
            kt = '0;
            kt[k*W +: W] = 32'h0100_0001 + k;
            put(1'b1, 32'h0000_0001, 32'h0000_0002, kt);
        end

        // R5: long back-to-back stream, distinct tables
        cur_tag = 5;
        for (int i = 0; i < 150; i++) begin
            rand_keys(kt);
            put(1'b1, $urandom, $urandom, kt);
        end

        // R8: invalid slots carrying junk
        cur_tag = 8;
        for (int i = 0; i < 40; i++) begin
            rand_keys(kt);
            put(i[0], $urandom, $urandom, kt);
        end
        idle(LAT + 5);

        // R6: reset while the pipeline is full
        cur_tag = 5;
        for (int i = 0; i < 30; i++) begin
            rand_keys(kt);
            put(1'b1, $urandom, $urandom, kt);
        end
        cur_tag = 6;
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(LAT + 10);
        rand_keys(kt);
        put(1'b1, $urandom, $urandom, kt);
        idle(LAT + 5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule